// File: doc/BRIEF.md
# Buffered-Compare Timer and Event Counter

This block is a 16-bit up-counter with two compare channels. Software configures it through a small register port. The count source is one of eight power-of-two divisions of the system clock, or a qualified edge on an external event pin. While counting is off, the counter is held at all ones, so the first count tick after enabling moves it to zero. A read of the counter while it is off returns zero.

Each compare channel has a register that software can read and write, and a buffer behind it that software cannot reach. Only the buffer takes part in matching. A write made while the timer is stopped reaches the buffer on the same clock edge. A write made while the timer runs is held until the counter rolls over from all ones to zero. When the counter steps onto a value equal to a channel's buffer, that channel's interrupt line pulses for one cycle. Channel 0 matches can also toggle an output pin.

Top module: `bufcmp_timer`

## Requirements
- R1: After reset, the control register, both compare registers, both compare buffers, matchIrq and toggleOut are all zero, and a counter read returns zero.
- R2: While the enable bit (control bit 0) is 0, a counter read returns 0000H and the internal count is FFFFH. The first count tick after enabling therefore produces count 0000H.
- R3: While enabled, each count tick adds one to the counter, and the counter wraps from FFFFH to 0000H.
- R4: With control bit 4 = 0, the tick comes from a free-running 7-bit prescaler that counts every clock from reset. With select code k in control bits 3:1, a tick occurs in each cycle where the low k prescaler bits are all ones, which divides the clock by 2^k.
- R5: With control bit 4 = 1, the event pin passes through two flip-flops and is then edge-detected. Control bits 6:5 select the edge: 00 none, 01 rising, 10 falling, 11 both. Each detected edge gives exactly one tick.
- R6: A compare write made while disabled loads that channel's buffer on the same edge as the register.
- R7: A compare write made while enabled updates the readable register at once. The buffer copies the register only on the tick that wraps the counter from FFFFH to 0000H.
- R8: matchIrq[i] is high for exactly the one cycle in which an enabled counter has just taken a new value equal to buffer i.
- R9: When control bit 7 is 1, toggleOut inverts on the clock edge that ends a cycle in which matchIrq[0] is high. Otherwise it holds its level.
- R10: Register addresses are 0 for control (bits 7:0, read back as written), 1 for compare 0, 2 for compare 1 and 3 for the counter. Address 3 is read-only, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational from rdAddr |
| evtIn | input | 1 | External event pin, asynchronous |
| matchIrq | output | 2 | Per-channel compare-match pulses |
| toggleOut | output | 1 | Output toggled by channel 0 matches |

## Verification
The assertions assume a single write per cycle at most, and an event pin that may change at any time, because it is synchronized inside the block. They also assume that mode bits change only through control writes. The bench drives every input on the falling clock edge from tasks. It changes the mode only through register writes and holds the event pin steady for at least one full cycle, so every edge reaches the synchronizer cleanly. A behavioural model predicts the read data, the interrupts and the toggle level on every cycle. It covers each clock division, each edge mode, and a compare write that has to wait through a full counter wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 16;
  localparam int NUM_CH   = 2;
  localparam int SEL_W    = 3;
  localparam int PRESC_W  = (1 << SEL_W) - 1;
  localparam int ADDR_W   = 2;
  localparam int CTL_W    = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd3;

  // control field positions
  localparam int BIT_EN   = 0;
  localparam int BIT_SEL  = 1;
  localparam int BIT_EXT  = 4;
  localparam int BIT_EDGE = 5;
  localparam int BIT_OUT  = 7;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic              tick;
    logic              countEn;
    logic              outEn;
    logic [NUM_CH-1:0] directLd;
    logic [CNT_W-1:0]  directVal;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [CNT_W-1:0]             wrData,
  input  logic                         evtIn,
  output tmrStrobe_t                   strb,
  output logic [CTL_W-1:0]             ctlReg,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmpReg
);
  logic [PRESC_W-1:0] prescQ;
  logic [2:0]         syncQ;
  logic               countEn, extSel, outEn;
  logic [SEL_W-1:0]   clkSel;
  edgeSel_e           edgeSel;
  logic [PRESC_W-1:0] selMask;
  logic               intTick, edgeHit, riseHit, fallHit;

  assign countEn = ctlReg[BIT_EN];
  assign clkSel  = ctlReg[BIT_SEL +: SEL_W];
  assign extSel  = ctlReg[BIT_EXT];
  assign edgeSel = edgeSel_e'(ctlReg[BIT_EDGE +: 2]);
  assign outEn   = ctlReg[BIT_OUT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlReg <= '0;
    else if (wrEn && wrAddr == ADDR_CTL) ctlReg <= wrData[CTL_W-1:0];
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MyAddr = ADDR_W'(ch + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cmpReg[ch] <= '0;
      else if (wrEn && wrAddr == MyAddr) cmpReg[ch] <= wrData;
    end
    assign strb.directLd[ch] = wrEn && (wrAddr == MyAddr) && !countEn;
  end

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescQ <= '0;
    else       prescQ <= prescQ + 1'b1;
  end

  assign selMask = PRESC_W'((1 << clkSel) - 1);
  assign intTick = (prescQ & selMask) == selMask;

  // event synchronizer: syncQ[1] is the synchronized level, syncQ[2] its previous value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], evtIn};
  end

  assign riseHit = syncQ[1] & ~syncQ[2];
  assign fallHit = ~syncQ[1] & syncQ[2];

  always_comb begin
    unique case (edgeSel)
      EDGE_RISE: edgeHit = riseHit;
      EDGE_FALL: edgeHit = fallHit;
      EDGE_BOTH: edgeHit = riseHit | fallHit;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign strb.tick      = countEn & (extSel ? edgeHit : intTick);
  assign strb.countEn   = countEn;
  assign strb.outEn     = outEn;
  assign strb.directVal = wrData;

  // R5: a rising-only event source cannot tick on two consecutive cycles
  a_r5_single_rise_tick: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && extSel && edgeSel == EDGE_RISE)
      |=> !(strb.tick && extSel && edgeSel == EDGE_RISE));

  // R4: the divide-by-two source never ticks on consecutive cycles
  a_r4_div2_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !extSel && clkSel == SEL_W'(1)) |=> !(strb.tick && !extSel && clkSel == SEL_W'(1)));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  tmrStrobe_t                   strb,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmpReg,
  output logic [CNT_W-1:0]             cntQ,
  output logic [NUM_CH-1:0]            matchIrq,
  output logic                         toggleOut
);
  localparam logic [CNT_W-1:0] AllOnes = '1;

  logic [NUM_CH-1:0][CNT_W-1:0] bufQ;
  logic                         movedQ;
  logic                         wrapNow;

  assign wrapNow = strb.tick && (cntQ == AllOnes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= AllOnes;
    else if (!strb.countEn) cntQ <= AllOnes;
    else if (strb.tick)     cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) movedQ <= 1'b0;
    else       movedQ <= strb.tick;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  bufQ[ch] <= '0;
      else if (strb.directLd[ch]) bufQ[ch] <= strb.directVal;
      else if (wrapNow)           bufQ[ch] <= cmpReg[ch];
    end

    assign matchIrq[ch] = strb.countEn & movedQ & (cntQ == bufQ[ch]);

    // R8: a match pulse follows a count tick in the previous cycle
    a_r8_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
      matchIrq[ch] |-> $past(strb.tick));

    // R7: while counting, a buffer changes only on the wrapping tick
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rstN)
      (strb.countEn && !(strb.tick && cntQ == AllOnes)) |=> $stable(bufQ[ch]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          toggleOut <= 1'b0;
    else if (matchIrq[0] && strb.outEn) toggleOut <= ~toggleOut;
  end

  // R3: the tick at all ones wraps to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && cntQ == AllOnes) |=> cntQ == '0);

  // R9: the output level moves only after a channel-0 match with output enabled
  a_r9_toggle_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toggleOut) |-> $past(matchIrq[0] && strb.outEn));
endmodule

// File: rtl/bufcmp_timer.sv
module bufcmp_timer
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]    rdData,
  input  logic                evtIn,
  output logic [NUM_CH-1:0]   matchIrq,
  output logic                toggleOut
);
  tmrStrobe_t                   strb;
  logic [CTL_W-1:0]             ctlReg;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0]             cntQ;

  tmr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .evtIn  (evtIn),
    .strb   (strb),
    .ctlReg (ctlReg),
    .cmpReg (cmpReg)
  );

  tmr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpReg    (cmpReg),
    .cntQ      (cntQ),
    .matchIrq  (matchIrq),
    .toggleOut (toggleOut)
  );

  always_comb begin
    if (rdAddr == ADDR_CTL)      rdData = CNT_W'(ctlReg);
    else if (rdAddr == ADDR_CNT) rdData = strb.countEn ? cntQ : '0;
    else                         rdData = cmpReg[rdAddr - 1'b1];
  end

  // R2: a disabled counter reads back as zero
  a_r2_idle_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && rdAddr == ADDR_CNT) |-> rdData == '0);
endmodule

// File: tb/bufcmp_timer_test.sv
module bufcmp_timer_test;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = 2'd3;
  logic        evtIn = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  matchIrq;
  logic        toggleOut;

  bufcmp_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn),
    .matchIrq(matchIrq), .toggleOut(toggleOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phaseReq = "R1";

  // behavioural model state
  int mCtl = 0, mCnt = 65535, mPresc = 0;
  int mCmp[2] = '{0, 0};
  int mBuf[2] = '{0, 0};
  bit mMoved = 0, mTog = 0, s1 = 0, s2 = 0, s3 = 0;

  function automatic bit mEn();  return mCtl[0]; endfunction
  function automatic int mSel(); return (mCtl >> 1) & 7; endfunction
  function automatic bit mExt(); return mCtl[4]; endfunction
  function automatic int mEdge(); return (mCtl >> 5) & 3; endfunction
  function automatic bit mOut(); return mCtl[7]; endfunction

  function automatic bit expIrq(int ch);
    return mEn() && mMoved && (mCnt == mBuf[ch]);
  endfunction

  function automatic int expRd(int a);
    case (a)
      0: return mCtl;
      1: return mCmp[0];
      2: return mCmp[1];
      default: return mEn() ? mCnt : 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtl = 0; mCnt = 65535; mPresc = 0; mCmp = '{0, 0}; mBuf = '{0, 0};
      mMoved = 0; mTog = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int  mask, nCtl, nCnt;
      int  nCmp[2], nBuf[2];
      bit  intTick, edgeHit, tick, rise, fall;
      mask = (1 << mSel()) - 1;
      intTick = (mPresc & mask) == mask;
      rise = s2 && !s3;
      fall = !s2 && s3;
      case (mEdge())
        1: edgeHit = rise;
        2: edgeHit = fall;
        3: edgeHit = rise || fall;
        default: edgeHit = 0;
      endcase
      tick = mEn() && (mExt() ? edgeHit : intTick);
      nCtl = mCtl; nCmp = mCmp; nBuf = mBuf;
      if (mEn() && tick && mCnt == 65535) nBuf = mCmp;
      if (wrEn) begin
        if (wrAddr == 0) nCtl = wrData & 8'hFF;
        if (wrAddr == 1 || wrAddr == 2) begin
          nCmp[wrAddr-1] = wrData;
          if (!mEn()) nBuf[wrAddr-1] = wrData;
        end
      end
      if (expIrq(0) && mOut()) mTog = !mTog;
      if (!mEn()) nCnt = 65535;
      else if (tick) nCnt = (mCnt + 1) % 65536;
      else nCnt = mCnt;
      mMoved = tick;
      mCtl = nCtl; mCmp = nCmp; mBuf = nBuf; mCnt = nCnt;
      mPresc = (mPresc + 1) % 128;
      s3 = s2; s2 = s1; s1 = evtIn;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    cycles++;
    checks++;
    if (rdData !== 16'(expRd(int'(rdAddr)))) begin
      errors++;
      $display("FAIL %s rdData addr %0d: actual %h expected %h", phaseReq, rdAddr, rdData, 16'(expRd(int'(rdAddr))));
    end
    checks++;
    if (matchIrq !== {expIrq(1), expIrq(0)}) begin
      errors++;
      $display("FAIL %s matchIrq: actual %b expected %b", phaseReq, matchIrq, {expIrq(1), expIrq(0)});
    end
    checks++;
    if (toggleOut !== mTog) begin
      errors++;
      $display("FAIL %s toggleOut: actual %b expected %b", phaseReq, toggleOut, mTog);
    end
    if (cycles > WatchdogCycles) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WatchdogCycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAll();
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      rdAddr = 2'(a);
    end
    @(negedge clk);
    rdAddr = 2'd3;
  endtask

  task automatic pulseEvt(int hi, int lo);
    @(negedge clk); evtIn = 1'b1;
    waitCyc(hi);
    evtIn = 1'b0;
    waitCyc(lo);
  endtask

  initial begin
    // R1: reset values
    phaseReq = "R1";
    waitCyc(3);
    rstN = 1'b1;
    readAll();

    // R10: the counter address is read-only
    phaseReq = "R10";
    regWrite(2'd3, 16'h1234);
    readAll();

    // R6: compare writes while stopped reach the buffers at once
    phaseReq = "R6";
    regWrite(2'd1, 16'd5);
    regWrite(2'd2, 16'd9);
    readAll();

    // R3, R8, R9: count every clock with the output toggle enabled
    phaseReq = "R8";
    regWrite(2'd0, 16'h0081);
    waitCyc(40);
    phaseReq = "R9";
    regWrite(2'd0, 16'h0000);
    regWrite(2'd0, 16'h0081);
    waitCyc(20);

    // R4: prescaled clock divisions
    phaseReq = "R4";
    for (int k = 1; k < 8; k++) begin
      regWrite(2'd0, 16'h0000);
      regWrite(2'd1, 16'd2);
      regWrite(2'd0, 16'(1 | (k << 1)));
      waitCyc(8 << k);
    end

    // R5: external events under each edge mode
    phaseReq = "R5";
    for (int m = 0; m < 4; m++) begin
      regWrite(2'd0, 16'h0000);
      regWrite(2'd1, 16'd3);
      regWrite(2'd2, 16'd1);
      regWrite(2'd0, 16'(1 | (1 << 4) | (m << 5) | (1 << 7)));
      for (int p = 0; p < 6; p++) pulseEvt(1 + p % 3, 2 + p % 2);
      waitCyc(5);
    end

    // R7: compare write while counting waits for the wrap
    phaseReq = "R7";
    regWrite(2'd0, 16'h0000);
    regWrite(2'd1, 16'd3);
    regWrite(2'd2, 16'd7);
    regWrite(2'd0, 16'h0001);
    waitCyc(10);
    regWrite(2'd1, 16'd100);
    regWrite(2'd2, 16'd65535);
    readAll();
    waitCyc(65536 + 150);

    // R2: disabling reads back zero and the next enable starts from zero
    phaseReq = "R2";
    regWrite(2'd0, 16'h0000);
    readAll();
    regWrite(2'd0, 16'h000F);
    waitCyc(300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule